// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the 32-bit general registers of a processor core that runs in several privilege and exception modes. Software in every mode addresses sixteen registers by a 4-bit index. Behind some of those indices sits a copy that belongs to one mode only. The block resolves each access from the index and the current mode. It offers two combinational read ports and one write port. It also keeps one saved-status word for each exception mode.

Two extra ports serve exception handling. An entry strobe stores the current status word and the return address into the target mode's saved status and link register in one cycle. A return strobe presents the active mode's saved status so that the surrounding core can restore its status register. Instruction decode, vector fetch and the ALU lie outside the block. The core keeps the live status word itself and only passes it in or takes it out.

Top module: `bankrf_top`

## Requirements
- R1: After reset, every register reads 0 in every mode, and every saved-status word reads 0.
- R2: Mode codes are 5 bits: user 10000, fast interrupt 10001, interrupt 10010, supervisor 10011, abort 10111, undefined 11011, system 11111. Any other code behaves as user. Indices 0 to 7 and index 15 name one copy that all modes share.
- R3: Fast-interrupt mode has its own indices 8 to 14. Its writes there never reach the user copies, and user writes to those indices never reach it.
- R4: Interrupt, supervisor, abort and undefined modes each have their own indices 13 and 14. Each shares indices 8 to 12 with user mode.
- R5: System mode maps every index to the user copy. It has no saved-status word.
- R6: An unknown mode code reaches the user copies, just as user mode does.
- R7: When `excEnter` is high and `excMode` names an exception mode, the block stores `statusIn` into that mode's saved status and `excRetAddr` into that mode's index 14 at one clock edge. An entry whose target is user, system or an unknown code changes nothing.
- R8: When `excReturn` is high in an exception mode, `restoreEn` is 1 and `savedRdData` carries that mode's saved status. In user, system or an unknown mode, `restoreEn` stays 0.
- R9: In user or system mode, `savedRdData` reads 0 and a saved-status write (`savedWrEn`) has no effect on any saved-status word.
- R10: A read of the physical register being written in the same cycle returns the new value. This holds for a port write and for the link write of an exception entry.
- R11: An exception entry wins over a port write that targets the same physical register in the same cycle. It also wins over a saved-status write that targets the same word.
- R12: The two read ports resolve their indices independently, against the same current mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| curMode | input | 5 | Current mode code |
| rdAddrA | input | 4 | Read port A index |
| rdDataA | output | 32 | Read port A data |
| rdAddrB | input | 4 | Read port B index |
| rdDataB | output | 32 | Read port B data |
| wrEn | input | 1 | Port write enable |
| wrAddr | input | 4 | Port write index |
| wrData | input | 32 | Port write data |
| savedWrEn | input | 1 | Write the current mode's saved status |
| savedWrData | input | 32 | Saved-status write data |
| savedRdData | output | 32 | Current mode's saved status (0 when the mode has none) |
| statusIn | input | 32 | Live status word, captured on exception entry |
| excEnter | input | 1 | Exception entry strobe |
| excMode | input | 5 | Mode being entered |
| excRetAddr | input | 32 | Return address for the link register |
| excReturn | input | 1 | Exception return strobe |
| restoreEn | output | 1 | The core should load `savedRdData` into its status |

## Verification
Assertions check on every cycle the following behaviours:
- A port read that hits the register being written returns the write data.
- User and system mode never expose a saved status or raise `restoreEn`.
- An accepted entry lands the status word and the return address in the target's storage, even when a colliding port write arrives in the same cycle.
- Low indices always resolve to the shared copies.

Only the bench's scenarios can show isolation between the banks. Examples are a fast-interrupt write to index 8 that stays hidden from user mode, a system-mode write that appears in user mode, and an entry aimed at system mode that leaves everything unchanged. Such checks need a write in one mode and a later read in another.

// File: rtl/bankrf_pkg.sv
package bankrf_pkg;
  localparam int DW = 32;
  localparam int IW = 4;
  localparam int MW = 5;
  localparam int NUM_SHARED = 16;
  localparam int FIQ_PRIV = 7;
  localparam int NUM_SMALL_BANKS = 4;
  localparam int NUM_PHYS = NUM_SHARED + FIQ_PRIV + 2 * NUM_SMALL_BANKS;
  localparam int PW = $clog2(NUM_PHYS);
  localparam int NUM_SAVED = 1 + NUM_SMALL_BANKS;
  localparam int SW = $clog2(NUM_SAVED);
  localparam int FIQ_BASE = NUM_SHARED;
  localparam int SMALL_BASE = NUM_SHARED + FIQ_PRIV;

  localparam logic [MW-1:0] MODE_USR = 5'b10000;
  localparam logic [MW-1:0] MODE_FIQ = 5'b10001;
  localparam logic [MW-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MW-1:0] MODE_SVC = 5'b10011;
  localparam logic [MW-1:0] MODE_ABT = 5'b10111;
  localparam logic [MW-1:0] MODE_UND = 5'b11011;
  localparam logic [MW-1:0] MODE_SYS = 5'b11111;

  typedef enum logic [2:0] {BK_USR, BK_FIQ, BK_IRQ, BK_SVC, BK_ABT, BK_UND} bank_e;

  typedef struct packed {
    logic [1:0][PW-1:0] rdPhys;
    logic               wrEn;
    logic [PW-1:0]      wrPhys;
    logic               excEn;
    logic [PW-1:0]      excPhys;
    logic [SW-1:0]      excSlot;
    logic               savedWrEn;
    logic [SW-1:0]      curSlot;
    logic               curHasSaved;
  } strobe_t;

  function automatic bank_e modeToBank(logic [MW-1:0] m);
    case (m)
      MODE_FIQ: return BK_FIQ;
      MODE_IRQ: return BK_IRQ;
      MODE_SVC: return BK_SVC;
      MODE_ABT: return BK_ABT;
      MODE_UND: return BK_UND;
      default:  return BK_USR;
    endcase
  endfunction

  function automatic logic [PW-1:0] physOf(bank_e b, logic [IW-1:0] idx);
    int i;
    i = int'(idx);
    if (b == BK_FIQ && i >= 8 && i <= 14)
      return PW'(FIQ_BASE + i - 8);
    if (b >= BK_IRQ && (i == 13 || i == 14))
      return PW'(SMALL_BASE + 2 * (int'(b) - int'(BK_IRQ)) + i - 13);
    return PW'(i);
  endfunction

  function automatic logic [SW-1:0] slotOf(bank_e b);
    return SW'(int'(b) - 1);
  endfunction
endpackage

// File: rtl/bankrf_ctrl.sv
module bankrf_ctrl
  import bankrf_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic [MW-1:0] curMode,
  input  logic [IW-1:0] rdAddrA,
  input  logic [IW-1:0] rdAddrB,
  input  logic          wrEn,
  input  logic [IW-1:0] wrAddr,
  input  logic          savedWrEn,
  input  logic          excEnter,
  input  logic [MW-1:0] excMode,
  output strobe_t       st
);
  bank_e curBank;
  bank_e excBank;
  logic [IW-1:0] rdAddr [2];

  assign curBank = modeToBank(curMode);
  assign excBank = modeToBank(excMode);
  assign rdAddr[0] = rdAddrA;
  assign rdAddr[1] = rdAddrB;

  for (genvar p = 0; p < 2; p++) begin : g_rdMap
    assign st.rdPhys[p] = physOf(curBank, rdAddr[p]);
  end

  always_comb begin
    st.wrEn        = wrEn;
    st.wrPhys      = physOf(curBank, wrAddr);
    st.excEn       = excEnter && (excBank != BK_USR);
    st.excPhys     = physOf(excBank, 4'd14);
    st.excSlot     = slotOf(excBank);
    st.curHasSaved = (curBank != BK_USR);
    st.savedWrEn   = savedWrEn && st.curHasSaved;
    st.curSlot     = slotOf(curBank);
  end

  // R2: low indices always resolve to the shared copies
  assert_low_shared_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddrA < 4'd8) |-> (st.rdPhys[0] == PW'(rdAddrA)));

  // R7: an accepted entry always targets a private link register
  assert_exc_private_link_R7: assert property (@(posedge clk) disable iff (!rstN)
    st.excEn |-> (st.excPhys >= PW'(NUM_SHARED)));
endmodule

// File: rtl/bankrf_dp.sv
module bankrf_dp
  import bankrf_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       st,
  input  logic [DW-1:0] wrData,
  input  logic [DW-1:0] excRetAddr,
  input  logic [DW-1:0] statusIn,
  input  logic [DW-1:0] savedWrData,
  input  logic          excReturn,
  output logic [DW-1:0] rdDataA,
  output logic [DW-1:0] rdDataB,
  output logic [DW-1:0] savedRdData,
  output logic          restoreEn
);
  logic [DW-1:0] gpr   [NUM_PHYS];
  logic [DW-1:0] saved [NUM_SAVED];
  logic [DW-1:0] rdData [2];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_PHYS; i++) gpr[i] <= '0;
      for (int j = 0; j < NUM_SAVED; j++) saved[j] <= '0;
    end else begin
      if (st.wrEn) gpr[st.wrPhys] <= wrData;
      if (st.excEn) gpr[st.excPhys] <= excRetAddr;
      if (st.savedWrEn) saved[st.curSlot] <= savedWrData;
      if (st.excEn) saved[st.excSlot] <= statusIn;
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_rdPort
    always_comb begin
      if (st.excEn && st.rdPhys[p] == st.excPhys)
        rdData[p] = excRetAddr;
      else if (st.wrEn && st.rdPhys[p] == st.wrPhys)
        rdData[p] = wrData;
      else
        rdData[p] = gpr[st.rdPhys[p]];
    end
  end

  assign rdDataA     = rdData[0];
  assign rdDataB     = rdData[1];
  assign savedRdData = st.curHasSaved ? saved[st.curSlot] : '0;
  assign restoreEn   = excReturn && st.curHasSaved;

  // R7: entry captures the status word in the target's saved slot
  assert_entry_saves_status_R7: assert property (@(posedge clk) disable iff (!rstN)
    st.excEn |=> (saved[$past(st.excSlot)] == $past(statusIn)));

  // R11: entry link write beats a colliding port write
  assert_entry_wins_R11: assert property (@(posedge clk) disable iff (!rstN)
    (st.excEn && st.wrEn && st.wrPhys == st.excPhys) |=> (gpr[$past(st.excPhys)] == $past(excRetAddr)));
endmodule

// File: rtl/bankrf_top.sv
module bankrf_top
  import bankrf_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic [MW-1:0] curMode,
  input  logic [IW-1:0] rdAddrA,
  output logic [DW-1:0] rdDataA,
  input  logic [IW-1:0] rdAddrB,
  output logic [DW-1:0] rdDataB,
  input  logic          wrEn,
  input  logic [IW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic          savedWrEn,
  input  logic [DW-1:0] savedWrData,
  output logic [DW-1:0] savedRdData,
  input  logic [DW-1:0] statusIn,
  input  logic          excEnter,
  input  logic [MW-1:0] excMode,
  input  logic [DW-1:0] excRetAddr,
  input  logic          excReturn,
  output logic          restoreEn
);
  strobe_t st;

  bankrf_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .curMode(curMode), .rdAddrA(rdAddrA), .rdAddrB(rdAddrB),
    .wrEn(wrEn), .wrAddr(wrAddr), .savedWrEn(savedWrEn), .excEnter(excEnter),
    .excMode(excMode), .st(st)
  );

  bankrf_dp dp_i (
    .clk(clk), .rstN(rstN), .st(st), .wrData(wrData), .excRetAddr(excRetAddr),
    .statusIn(statusIn), .savedWrData(savedWrData), .excReturn(excReturn),
    .rdDataA(rdDataA), .rdDataB(rdDataB), .savedRdData(savedRdData), .restoreEn(restoreEn)
  );

  // R10: same-cycle read of the written index returns the new data
  assert_bypass_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !excEnter && rdAddrA == wrAddr) |-> (rdDataA == wrData));

  // R9: user and system expose no saved status
  assert_no_saved_R9: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == MODE_USR || curMode == MODE_SYS) |-> (savedRdData == '0 && !restoreEn));
endmodule

// File: tb/bankrf_top_tb_top.sv
`timescale 1ns/1ps
module bankrf_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] curMode = 5'b10000, excMode = 5'b10000;
  logic [3:0] rdAddrA = '0, rdAddrB = '0, wrAddr = '0;
  logic [31:0] rdDataA, rdDataB, wrData = '0, savedWrData = '0, savedRdData;
  logic [31:0] statusIn = '0, excRetAddr = '0;
  logic wrEn = 0, savedWrEn = 0, excEnter = 0, excReturn = 0, restoreEn;

  int nChecks = 0, nFails = 0;
  bit done = 0;
  logic [31:0] mdl [0:127];
  logic [31:0] mdlSaved [0:7];

  localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010, SVC = 5'b10011,
                         ABT = 5'b10111, UND = 5'b11011, SYS = 5'b11111, BAD = 5'b00011;

  always #2.5 clk = ~clk;

  bankrf_top dut_i (
    .clk(clk), .rstN(rstN), .curMode(curMode), .rdAddrA(rdAddrA), .rdDataA(rdDataA),
    .rdAddrB(rdAddrB), .rdDataB(rdDataB), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .savedWrEn(savedWrEn), .savedWrData(savedWrData), .savedRdData(savedRdData),
    .statusIn(statusIn), .excEnter(excEnter), .excMode(excMode), .excRetAddr(excRetAddr),
    .excReturn(excReturn), .restoreEn(restoreEn)
  );

  function automatic int grpOf(logic [4:0] m);
    case (m)
      FIQ: return 1; IRQ: return 2; SVC: return 3; ABT: return 4; UND: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic int keyOf(logic [4:0] m, logic [3:0] idx);
    int g = grpOf(m);
    int i = int'(idx);
    if (i == 13 || i == 14) return g * 16 + i;
    if (i >= 8 && i <= 12 && g == 1) return 16 + i;
    return i;
  endfunction

  function automatic logic [31:0] expRead(logic [3:0] idx);
    int k = keyOf(curMode, idx);
    if (excEnter && grpOf(excMode) != 0 && k == keyOf(excMode, 4'd14)) return excRetAddr;
    if (wrEn && k == keyOf(curMode, wrAddr)) return wrData;
    return mdl[k];
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wrEn = 0; savedWrEn = 0; excEnter = 0; excReturn = 0;
  endtask

  task automatic cyc(string tag);
    int g;
    #1;
    g = grpOf(curMode);
    check({tag, " portA"}, rdDataA, expRead(rdAddrA));
    check({tag, " portB"}, rdDataB, expRead(rdAddrB));
    check({tag, " saved"}, savedRdData, (g == 0) ? 32'h0 : mdlSaved[g]);
    check({tag, " restore"}, {31'h0, restoreEn}, {31'h0, excReturn && g != 0});
    @(posedge clk);
    if (wrEn) mdl[keyOf(curMode, wrAddr)] = wrData;
    if (savedWrEn && g != 0) mdlSaved[g] = savedWrData;
    if (excEnter && grpOf(excMode) != 0) begin
      mdl[keyOf(excMode, 4'd14)] = excRetAddr;
      mdlSaved[grpOf(excMode)] = statusIn;
    end
    @(negedge clk);
  endtask

  task automatic wr(logic [4:0] m, logic [3:0] a, logic [31:0] d, string tag);
    idle(); curMode = m; wrEn = 1; wrAddr = a; wrData = d;
    cyc(tag);
    idle();
  endtask

  task automatic rdLit(logic [4:0] m, logic [3:0] a, logic [31:0] expA, string tag);
    idle(); curMode = m; rdAddrA = a;
    #1 check(tag, rdDataA, expA);
    cyc(tag);
  endtask

  function automatic logic [4:0] pickMode(int r);
    case (r % 8)
      0: return USR; 1: return FIQ; 2: return IRQ; 3: return SVC;
      4: return ABT; 5: return UND; 6: return SYS; default: return BAD;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) mdl[i] = '0;
    for (int i = 0; i < 8; i++) mdlSaved[i] = '0;
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1: reset state
    for (int i = 0; i < 16; i++) rdLit(USR, 4'(i), 32'h0, "R1 user reset");
    rdLit(FIQ, 4'd9, 32'h0, "R1 fiq reset");
    idle(); curMode = FIQ; #1 check("R1 saved reset", savedRdData, 32'h0); cyc("R1");

    // R2: shared low indices and r15
    wr(USR, 4'd3, 32'h1111_0003, "R2 wr");
    rdLit(FIQ, 4'd3, 32'h1111_0003, "R2 shared r3");
    wr(IRQ, 4'd15, 32'h0000_F00D, "R2 wr15");
    rdLit(SYS, 4'd15, 32'h0000_F00D, "R2 shared r15");

    // R3: fast-interrupt private 8..14
    wr(USR, 4'd8, 32'h8888_0008, "R3 wr usr");
    wr(FIQ, 4'd8, 32'h0000_00F8, "R3 wr fiq");
    rdLit(USR, 4'd8, 32'h8888_0008, "R3 user r8 unaffected");
    rdLit(FIQ, 4'd8, 32'h0000_00F8, "R3 fiq r8 private");
    wr(FIQ, 4'd13, 32'h0000_0F13, "R3 wr fiq r13");
    rdLit(USR, 4'd13, 32'h0, "R3 user r13 unaffected");

    // R4: small banks
    wr(SVC, 4'd13, 32'h0000_005D, "R4 wr svc");
    rdLit(IRQ, 4'd13, 32'h0, "R4 irq r13 private");
    rdLit(SVC, 4'd13, 32'h0000_005D, "R4 svc r13");
    rdLit(ABT, 4'd8, 32'h8888_0008, "R4 abt shares r8");

    // R5: system maps to user
    wr(SYS, 4'd14, 32'h0000_0E14, "R5 wr sys");
    rdLit(USR, 4'd14, 32'h0000_0E14, "R5 sys is user copy");
    idle(); curMode = SYS; #1 check("R5 sys no saved", savedRdData, 32'h0); cyc("R5");

    // R6: unknown code behaves as user
    wr(BAD, 4'd13, 32'h0000_0077, "R6 wr bad");
    rdLit(USR, 4'd13, 32'h0000_0077, "R6 unknown is user");

    // R7: exception entry
    idle(); curMode = USR; statusIn = 32'h6000_00D3; excEnter = 1; excMode = IRQ;
    excRetAddr = 32'h0000_0400; cyc("R7 entry");
    rdLit(IRQ, 4'd14, 32'h0000_0400, "R7 link stored");
    idle(); curMode = IRQ; #1 check("R7 status saved", savedRdData, 32'h6000_00D3); cyc("R7");
    rdLit(USR, 4'd14, 32'h0000_0E14, "R7 user link untouched");
    idle(); excEnter = 1; excMode = SYS; excRetAddr = 32'h999; curMode = USR; cyc("R7 sys entry");
    rdLit(USR, 4'd14, 32'h0000_0E14, "R7 system entry ignored");

    // R8: exception return
    idle(); curMode = IRQ; excReturn = 1;
    #1 check("R8 restoreEn", {31'h0, restoreEn}, 32'h1);
    check("R8 restore value", savedRdData, 32'h6000_00D3); cyc("R8");
    idle(); curMode = SYS; excReturn = 1;
    #1 check("R8 sys no restore", {31'h0, restoreEn}, 32'h0); cyc("R8");

    // R9: saved write in user ignored
    idle(); curMode = USR; savedWrEn = 1; savedWrData = 32'h123; cyc("R9 wr");
    idle(); curMode = USR; #1 check("R9 user saved zero", savedRdData, 32'h0); cyc("R9");
    idle(); curMode = IRQ; #1 check("R9 irq saved kept", savedRdData, 32'h6000_00D3); cyc("R9");
    idle(); curMode = FIQ; #1 check("R9 fiq saved kept", savedRdData, 32'h0); cyc("R9");

    // R10: same-cycle bypass
    idle(); curMode = FIQ; wrEn = 1; wrAddr = 4'd9; wrData = 32'hB9; rdAddrA = 4'd9; rdAddrB = 4'd9;
    #1 check("R10 bypass", rdDataA, 32'hB9); cyc("R10");
    idle(); curMode = ABT; excEnter = 1; excMode = ABT; excRetAddr = 32'hAB14; rdAddrA = 4'd14;
    #1 check("R10 entry bypass", rdDataA, 32'hAB14); cyc("R10");

    // R11: entry wins on collision
    idle(); curMode = UND; wrEn = 1; wrAddr = 4'd14; wrData = 32'h1;
    savedWrEn = 1; savedWrData = 32'h5A5A;
    excEnter = 1; excMode = UND; excRetAddr = 32'h2; statusIn = 32'h1F; cyc("R11 collide");
    rdLit(UND, 4'd14, 32'h2, "R11 link from entry");
    idle(); curMode = UND; #1 check("R11 status from entry", savedRdData, 32'h1F); cyc("R11");

    // R12: independent ports
    idle(); curMode = FIQ; rdAddrA = 4'd8; rdAddrB = 4'd3;
    #1 check("R12 portA", rdDataA, 32'hF8); check("R12 portB", rdDataB, 32'h1111_0003); cyc("R12");

    // R12: random mix against the model
    for (int n = 0; n < 4000; n++) begin
      idle();
      curMode = pickMode($urandom);
      rdAddrA = 4'($urandom); rdAddrB = 4'($urandom);
      wrEn = ($urandom % 2) == 0; wrAddr = 4'($urandom); wrData = $urandom;
      savedWrEn = ($urandom % 8) == 0; savedWrData = $urandom;
      excEnter = ($urandom % 8) == 0; excMode = pickMode($urandom); excRetAddr = $urandom;
      statusIn = $urandom; excReturn = ($urandom % 4) == 0;
      cyc("R12 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule